// File: doc/BRIEF.md
# Posted Write Queue with Ordering

This block sits between a local processor bus and a shared system-bus master. In decoupled mode, a processor write is stored in a queue together with its address, data and control bits. The write is acknowledged in the same cycle it is presented, and the queue drains onto the bus in the background. Reads, interrupt acknowledges and every access made in atomic mode run straight through to the bus. They start only after every queued write has finished, so a read can never pass an older write.

A bus error stops all bus activity and sets a sticky error flag, which can raise an interrupt. The failed write is dropped and is not retried. Its address, data and control stay visible on the diagnostic outputs, and draining resumes once software clears the flag. A write that meets a full queue is held in wait. If the local timeout is enabled, a prescaled timer ends that wait with a local bus error.

Top module: `posted_write_queue`

## Requirements
- R1: The queue holds DEPTH (default 15) entries, each made of address, data and control. One more entry sits in the output stage, and queued writes reach the bus in the order they were accepted.
- R2: With `mode_dcpl` low, a write is not queued. It runs directly on the bus, and `cpu_ack` rises only in the cycle the bus acknowledges it.
- R3: With `mode_dcpl` high and room in the queue, a plain write (`cpu_we`=1, `cpu_iack`=0) receives `cpu_ack` in the same cycle it is presented.
- R4: Reads (`cpu_we`=0) and interrupt acknowledges (`cpu_iack`=1) always run directly, whatever the mode. They start only when the queue is empty and no queued write is in flight. Read data from `bus_rdata` is returned with `cpu_ack`.
- R5: A `bus_err` during a bus cycle sets `st_berr` on the next clock edge. `irq` equals `st_berr` AND `irq_en`. A direct access that fails ends with `cpu_err`.
- R6: No new bus cycle starts while `st_berr` is set. After it is cleared, the remaining queued writes drain and the failed write is not issued again.
- R7: `diag_addr`, `diag_data` and `diag_ctl` show the last entry taken from the queue. They stay unchanged after a bus error until a later entry leaves the queue.
- R8: A decoupled write that meets a full queue gets no `cpu_ack`. With `to_en` low it waits without limit and completes once room appears.
- R9: With `to_en` high, a write held on a full queue for CLK_MHZ*TIMEOUT_US cycles receives a one-cycle `cpu_err`, and both `st_lberr` and `st_lto` become set. The timer restarts on every successful enqueue.
- R10: Each status flag is cleared by a one-cycle pulse on its `clr_*` input. The flags are independent, and a set in the same cycle wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_dcpl | input | 1 | 1 = decoupled (posted) writes, 0 = atomic |
| to_en | input | 1 | Enables the local wait timeout |
| irq_en | input | 1 | Interrupt enable for the bus-error flag |
| cpu_req | input | 1 | Processor access request, held until ack or error |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_iack | input | 1 | Interrupt-acknowledge access |
| cpu_addr | input | AW | Access address |
| cpu_wdata | input | DW | Write data |
| cpu_ctl | input | CTLW | Control code (size, space) carried with the access |
| cpu_ack | output | 1 | Access complete |
| cpu_err | output | 1 | Access ended with an error (bus error or timeout) |
| cpu_rdata | output | DW | Read data, valid with cpu_ack |
| bus_req | output | 1 | Bus cycle active |
| bus_we | output | 1 | Bus cycle is a write |
| bus_iack | output | 1 | Bus cycle is an interrupt acknowledge |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_ctl | output | CTLW | Bus control code |
| bus_ack | input | 1 | Bus cycle acknowledged |
| bus_err | input | 1 | Bus cycle failed |
| bus_rdata | input | DW | Bus read data |
| clr_berr | input | 1 | Clear pulse for st_berr |
| clr_lberr | input | 1 | Clear pulse for st_lberr |
| clr_lto | input | 1 | Clear pulse for st_lto |
| st_berr | output | 1 | Sticky bus-error flag |
| st_lberr | output | 1 | Sticky local-bus-error flag |
| st_lto | output | 1 | Sticky local-timeout flag |
| irq | output | 1 | Interrupt request |
| diag_addr | output | AW | Address of the output-stage entry |
| diag_data | output | DW | Data of the output-stage entry |
| diag_ctl | output | CTLW | Control of the output-stage entry |

## Verification
The hardest state to reach is a bus error on a write in the middle of the queue, with more writes still waiting behind it. The bench stalls the modelled bus slave and loads three posted writes. It then arms the slave to fail the second completion and releases the stall. This shows that the first write lands, the second is dropped but stays visible on the diagnostic outputs, and the third is held until the flag is cleared. The timeout is reached by filling the queue and the output stage against the stalled slave, then presenting one more write. The bench uses a short TIMEOUT_US so that the expiry cycle can be checked exactly.

// File: rtl/pwq_pkg.sv
package pwq_pkg;
   typedef enum logic [1:0] {
      DR_IDLE   = 2'd0,
      DR_POST   = 2'd1,
      DR_DIRECT = 2'd2
   } drain_st_t;
endpackage

// File: rtl/pwq_fifo.sv
module pwq_fifo #(
   parameter int W     = 68,
   parameter int DEPTH = 15
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("pwq_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] cnt;

   function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign full  = (cnt == CW'(DEPTH));
   assign empty = (cnt == '0);
   assign dout  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push && !full) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push && !full) wr_ptr <= bump(wr_ptr);
         if (pop && !empty) rd_ptr <= bump(rd_ptr);
         case ({push && !full, pop && !empty})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/pwq_timeout.sv
module pwq_timeout #(
   parameter int CLK_MHZ    = 250,
   parameter int TIMEOUT_US = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic waiting,
   input  logic enable,
   input  logic restart,
   output logic expired
);
   localparam int UW = $clog2(TIMEOUT_US + 1);

   generate
      if (CLK_MHZ < 1 || TIMEOUT_US < 1) begin : g_bad_cfg
         $error("pwq_timeout: CLK_MHZ and TIMEOUT_US must be positive");
      end
   endgenerate

   logic [UW-1:0] us_cnt;
   logic          us_tick;
   logic          hold;

   assign hold    = !waiting || restart || expired;
   assign expired = waiting && enable && (us_cnt == UW'(TIMEOUT_US));

   generate
      if (CLK_MHZ > 1) begin : g_prescale
         localparam int PRW = $clog2(CLK_MHZ);
         logic [PRW-1:0] pre;
         assign us_tick = (pre == PRW'(CLK_MHZ - 1));
         always_ff @(posedge clk) begin
            if (!rst_n || hold || us_tick) pre <= '0;
            else                           pre <= pre + 1'b1;
         end
      end else begin : g_direct
         assign us_tick = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || hold)                               us_cnt <= '0;
      else if (us_tick && us_cnt != UW'(TIMEOUT_US))   us_cnt <= us_cnt + 1'b1;
   end
endmodule

// File: rtl/pwq_drain.sv
module pwq_drain
   import pwq_pkg::*;
#(
   parameter int AW   = 32,
   parameter int DW   = 32,
   parameter int CTLW = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            halt,
   input  logic            q_empty,
   input  logic [AW-1:0]   q_addr,
   input  logic [DW-1:0]   q_data,
   input  logic [CTLW-1:0] q_ctl,
   output logic            q_pop,
   input  logic            dir_pend,
   input  logic            cpu_we,
   input  logic            cpu_iack,
   input  logic [AW-1:0]   cpu_addr,
   input  logic [DW-1:0]   cpu_wdata,
   input  logic [CTLW-1:0] cpu_ctl,
   output logic            bus_req,
   output logic            bus_we,
   output logic            bus_iack,
   output logic [AW-1:0]   bus_addr,
   output logic [DW-1:0]   bus_wdata,
   output logic [CTLW-1:0] bus_ctl,
   input  logic            bus_ack,
   input  logic            bus_err,
   output logic            dir_done,
   output logic            dir_fail,
   output logic            fail_set,
   output logic [AW-1:0]   stg_addr,
   output logic [DW-1:0]   stg_data,
   output logic [CTLW-1:0] stg_ctl
);
   drain_st_t st, st_nx;
   logic      go_dir;
   logic      is_dir;

   assign q_pop  = (st == DR_IDLE) && !halt && !q_empty;
   assign go_dir = (st == DR_IDLE) && !halt && q_empty && dir_pend;
   assign is_dir = (st == DR_DIRECT);

   always_comb begin
      st_nx = st;
      unique case (st)
         DR_IDLE:   if (q_pop) st_nx = DR_POST; else if (go_dir) st_nx = DR_DIRECT;
         DR_POST,
         DR_DIRECT: if (bus_ack || bus_err) st_nx = DR_IDLE;
         default:   st_nx = DR_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= DR_IDLE;
      else        st <= st_nx;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stg_addr <= '0;
         stg_data <= '0;
         stg_ctl  <= '0;
      end else if (q_pop) begin
         stg_addr <= q_addr;
         stg_data <= q_data;
         stg_ctl  <= q_ctl;
      end
   end

   assign bus_req   = (st != DR_IDLE);
   assign bus_we    = is_dir ? (cpu_we && !cpu_iack) : bus_req;
   assign bus_iack  = is_dir && cpu_iack;
   assign bus_addr  = is_dir ? cpu_addr  : stg_addr;
   assign bus_wdata = is_dir ? cpu_wdata : stg_data;
   assign bus_ctl   = is_dir ? cpu_ctl   : stg_ctl;
   assign dir_done  = is_dir && bus_ack;
   assign dir_fail  = is_dir && bus_err;
   assign fail_set  = bus_req && bus_err;
endmodule

// File: rtl/posted_write_queue.sv
module posted_write_queue #(
   parameter int AW         = 32,
   parameter int DW         = 32,
   parameter int CTLW       = 4,
   parameter int DEPTH      = 15,
   parameter int CLK_MHZ    = 250,
   parameter int TIMEOUT_US = 512
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mode_dcpl,
   input  logic            to_en,
   input  logic            irq_en,
   input  logic            cpu_req,
   input  logic            cpu_we,
   input  logic            cpu_iack,
   input  logic [AW-1:0]   cpu_addr,
   input  logic [DW-1:0]   cpu_wdata,
   input  logic [CTLW-1:0] cpu_ctl,
   output logic            cpu_ack,
   output logic            cpu_err,
   output logic [DW-1:0]   cpu_rdata,
   output logic            bus_req,
   output logic            bus_we,
   output logic            bus_iack,
   output logic [AW-1:0]   bus_addr,
   output logic [DW-1:0]   bus_wdata,
   output logic [CTLW-1:0] bus_ctl,
   input  logic            bus_ack,
   input  logic            bus_err,
   input  logic [DW-1:0]   bus_rdata,
   input  logic            clr_berr,
   input  logic            clr_lberr,
   input  logic            clr_lto,
   output logic            st_berr,
   output logic            st_lberr,
   output logic            st_lto,
   output logic            irq,
   output logic [AW-1:0]   diag_addr,
   output logic [DW-1:0]   diag_data,
   output logic [CTLW-1:0] diag_ctl
);
   localparam int EW = AW + DW + CTLW;

   generate
      if (AW < 1 || DW < 1 || CTLW < 1) begin : g_bad_width
         $error("posted_write_queue: widths must be positive");
      end
   endgenerate

   logic          posted, push, dir_pend;
   logic          q_full, q_empty, q_pop;
   logic [EW-1:0] q_head;
   logic          dir_done, dir_fail, fail_set, to_exp;

   assign posted   = cpu_req && cpu_we && !cpu_iack && mode_dcpl;
   assign push     = posted && !q_full;
   assign dir_pend = cpu_req && !posted;

   pwq_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .din   ({cpu_ctl, cpu_addr, cpu_wdata}),
      .pop   (q_pop),
      .dout  (q_head),
      .full  (q_full),
      .empty (q_empty)
   );

   pwq_drain #(.AW(AW), .DW(DW), .CTLW(CTLW)) u_drain (
      .clk       (clk),
      .rst_n     (rst_n),
      .halt      (st_berr),
      .q_empty   (q_empty),
      .q_addr    (q_head[DW +: AW]),
      .q_data    (q_head[DW-1:0]),
      .q_ctl     (q_head[EW-1 -: CTLW]),
      .q_pop     (q_pop),
      .dir_pend  (dir_pend),
      .cpu_we    (cpu_we),
      .cpu_iack  (cpu_iack),
      .cpu_addr  (cpu_addr),
      .cpu_wdata (cpu_wdata),
      .cpu_ctl   (cpu_ctl),
      .bus_req   (bus_req),
      .bus_we    (bus_we),
      .bus_iack  (bus_iack),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_ctl   (bus_ctl),
      .bus_ack   (bus_ack),
      .bus_err   (bus_err),
      .dir_done  (dir_done),
      .dir_fail  (dir_fail),
      .fail_set  (fail_set),
      .stg_addr  (diag_addr),
      .stg_data  (diag_data),
      .stg_ctl   (diag_ctl)
   );

   pwq_timeout #(.CLK_MHZ(CLK_MHZ), .TIMEOUT_US(TIMEOUT_US)) u_tmo (
      .clk     (clk),
      .rst_n   (rst_n),
      .waiting (posted && q_full),
      .enable  (to_en),
      .restart (push),
      .expired (to_exp)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_berr  <= 1'b0;
         st_lberr <= 1'b0;
         st_lto   <= 1'b0;
      end else begin
         st_berr  <= (st_berr  && !clr_berr)  || fail_set;
         st_lberr <= (st_lberr && !clr_lberr) || to_exp;
         st_lto   <= (st_lto   && !clr_lto)   || to_exp;
      end
   end

   assign cpu_ack   = push || dir_done;
   assign cpu_err   = to_exp || dir_fail;
   assign cpu_rdata = bus_rdata;
   assign irq       = st_berr && irq_en;
endmodule

// File: rtl/pwq_chk.sv
module pwq_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mode_dcpl,
   input logic          cpu_req,
   input logic          cpu_we,
   input logic          cpu_iack,
   input logic          cpu_ack,
   input logic          cpu_err,
   input logic          bus_req,
   input logic          bus_we,
   input logic          bus_iack,
   input logic          bus_err,
   input logic          st_berr,
   input logic          st_lberr,
   input logic          st_lto,
   input logic          q_full,
   input logic          q_empty,
   input logic [AW-1:0] diag_addr
);
   // R3
   post_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_we && !cpu_iack && mode_dcpl && !q_full) |-> cpu_ack);

   // R8
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_we && !cpu_iack && mode_dcpl && q_full) |-> !cpu_ack);

   // R4
   direct_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(bus_req) && (!bus_we || bus_iack)) |-> q_empty);

   // R5
   berr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_err) |=> st_berr);

   // R6
   halt_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_req) |-> !$past(st_berr));

   // R7
   diag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_err && bus_we) |=> $stable(diag_addr));

   // R9
   lto_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_err && !bus_req) |=> (st_lto && st_lberr));
endmodule

bind posted_write_queue pwq_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_dcpl (mode_dcpl),
   .cpu_req   (cpu_req),
   .cpu_we    (cpu_we),
   .cpu_iack  (cpu_iack),
   .cpu_ack   (cpu_ack),
   .cpu_err   (cpu_err),
   .bus_req   (bus_req),
   .bus_we    (bus_we),
   .bus_iack  (bus_iack),
   .bus_err   (bus_err),
   .st_berr   (st_berr),
   .st_lberr  (st_lberr),
   .st_lto    (st_lto),
   .q_full    (q_full),
   .q_empty   (q_empty),
   .diag_addr (diag_addr)
);

// File: tb/posted_write_queue_bench.sv
module posted_write_queue_bench;
   localparam int CLK_MHZ = 250;
   localparam int TO_US   = 2;
   localparam int LIMIT   = CLK_MHZ * TO_US;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_dcpl = 1'b1, to_en = 1'b0, irq_en = 1'b1;
   logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_iack = 1'b0;
   logic [31:0] cpu_addr = '0, cpu_wdata = '0;
   logic [3:0]  cpu_ctl = '0;
   logic        cpu_ack, cpu_err;
   logic [31:0] cpu_rdata;
   logic        bus_req, bus_we, bus_iack;
   logic [31:0] bus_addr, bus_wdata;
   logic [3:0]  bus_ctl;
   logic        bus_ack, bus_err;
   logic [31:0] bus_rdata;
   logic        clr_berr = 1'b0, clr_lberr = 1'b0, clr_lto = 1'b0;
   logic        st_berr, st_lberr, st_lto, irq;
   logic [31:0] diag_addr, diag_data;
   logic [3:0]  diag_ctl;

   always #2 clk = ~clk;

   posted_write_queue #(.CLK_MHZ(CLK_MHZ), .TIMEOUT_US(TO_US)) u_posted_write_queue (
      .clk(clk), .rst_n(rst_n), .mode_dcpl(mode_dcpl), .to_en(to_en), .irq_en(irq_en),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_iack(cpu_iack), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_ctl(cpu_ctl), .cpu_ack(cpu_ack), .cpu_err(cpu_err),
      .cpu_rdata(cpu_rdata), .bus_req(bus_req), .bus_we(bus_we), .bus_iack(bus_iack),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ctl(bus_ctl), .bus_ack(bus_ack),
      .bus_err(bus_err), .bus_rdata(bus_rdata), .clr_berr(clr_berr), .clr_lberr(clr_lberr),
      .clr_lto(clr_lto), .st_berr(st_berr), .st_lberr(st_lberr), .st_lto(st_lto), .irq(irq),
      .diag_addr(diag_addr), .diag_data(diag_data), .diag_ctl(diag_ctl)
   );

   // bus slave model: fixed latency, stall control, error on a chosen completion
   logic        stall = 1'b1;
   int          lat = 1;
   int          err_at = -1;
   int          dly, done_n, log_n;
   logic [31:0] log_a [64];
   logic [31:0] log_d [64];
   logic [1:0]  log_k [64];

   assign bus_rdata = ~bus_addr;

   always @(posedge clk) begin
      bus_ack <= 1'b0;
      bus_err <= 1'b0;
      if (!rst_n) begin
         dly <= 0; done_n <= 0; log_n <= 0;
      end else if (bus_req && !bus_ack && !bus_err && !stall) begin
         if (dly < lat) dly <= dly + 1;
         else begin
            dly    <= 0;
            done_n <= done_n + 1;
            if (done_n == err_at) bus_err <= 1'b1;
            else begin
               bus_ack      <= 1'b1;
               log_a[log_n] <= bus_addr;
               log_d[log_n] <= bus_wdata;
               log_k[log_n] <= bus_iack ? 2'd2 : (bus_we ? 2'd0 : 2'd1);
               log_n        <= log_n + 1;
            end
         end
      end
   end

   int checks = 0, errors = 0;
   bit done_flag = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cpu_access(input logic we, input logic iack, input logic [31:0] a,
                             input logic [31:0] d, input int maxw, output int waits,
                             output logic ok, output logic er, output logic [31:0] rd);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_iack = iack;
      cpu_addr = a; cpu_wdata = d; cpu_ctl = a[3:0];
      waits = 0; ok = 1'b0; er = 1'b0; rd = '0;
      forever begin
         #1;
         if (cpu_ack) begin ok = 1'b1; rd = cpu_rdata; break; end
         if (cpu_err) begin er = 1'b1; break; end
         if (waits >= maxw) break;
         @(negedge clk);
         waits++;
      end
      @(negedge clk);
      cpu_req = 1'b0; cpu_we = 1'b0; cpu_iack = 1'b0;
   endtask

   task automatic wait_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      if (which == 0) clr_berr = 1'b1;
      if (which == 1) clr_lberr = 1'b1;
      if (which == 2) clr_lto = 1'b1;
      @(negedge clk);
      clr_berr = 1'b0; clr_lberr = 1'b0; clr_lto = 1'b0;
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(!bus_req, "reset bus_req", 32'(bus_req), 0);
      chk(!st_berr && !st_lberr && !st_lto, "reset flags R10",
          {29'd0, st_berr, st_lberr, st_lto}, 0);
      chk(!irq && !cpu_ack, "reset irq/ack R5", {30'd0, irq, cpu_ack}, 0);
   endtask

   task automatic t_posted;
      int w; logic ok, er; logic [31:0] rd;
      int n0 = log_n;
      stall = 1'b0; lat = 2; mode_dcpl = 1'b1;
      for (int i = 0; i < 4; i++) begin
         cpu_access(1'b1, 1'b0, 32'h1000 + 32'(i*4), 32'hD0 + 32'(i), 10, w, ok, er, rd);
         chk(ok && w == 0, "R3 zero-wait posted ack", 32'(w), 0);
      end
      // read right behind the posted writes
      cpu_access(1'b0, 1'b0, 32'h2000, 0, 200, w, ok, er, rd);
      chk(ok, "R4 read completes", 32'(ok), 1);
      chk(log_n == n0 + 5, "R4 read after all writes", 32'(log_n - n0), 5);
      chk(log_k[n0+4] == 2'd1 && log_a[n0+4] == 32'h2000, "R4 read is last bus cycle",
          log_a[n0+4], 32'h2000);
      chk(rd == ~32'h2000, "R4 read data", rd, ~32'h2000);
      for (int i = 0; i < 4; i++)
         chk(log_a[n0+i] == 32'h1000 + 32'(i*4) && log_d[n0+i] == 32'hD0 + 32'(i),
             "R1 write order", log_a[n0+i], 32'h1000 + 32'(i*4));
   endtask

   task automatic t_atomic;
      int w; logic ok, er; logic [31:0] rd;
      int n0 = log_n;
      mode_dcpl = 1'b0; lat = 2;
      cpu_access(1'b1, 1'b0, 32'h3000, 32'h33, 100, w, ok, er, rd);
      chk(ok && w > 0, "R2 atomic write waits", 32'(w), 1);
      chk(log_n == n0 + 1 && log_a[n0] == 32'h3000 && log_k[n0] == 2'd0,
          "R2 atomic write on bus at ack", 32'(log_n - n0), 1);
      mode_dcpl = 1'b1;
      cpu_access(1'b0, 1'b1, 32'h7, 0, 100, w, ok, er, rd);
      chk(ok && w > 0 && log_k[n0+1] == 2'd2, "R4 iack always direct",
          32'(log_k[n0+1]), 2);
   endtask

   task automatic t_buserr;
      int w; logic ok, er; logic [31:0] rd;
      int n0, busy;
      stall = 1'b1; lat = 0; irq_en = 1'b1;
      n0 = log_n;
      for (int i = 0; i < 3; i++)
         cpu_access(1'b1, 1'b0, 32'h4000 + 32'(i*16), 32'hE0 + 32'(i), 10, w, ok, er, rd);
      err_at = done_n + 1;
      stall = 1'b0;
      wait_cycles(30);
      chk(st_berr, "R5 bus error flag", 32'(st_berr), 1);
      chk(irq, "R5 irq with enable", 32'(irq), 1);
      chk(log_n == n0 + 1 && log_a[n0] == 32'h4000, "R6 only first write landed",
          32'(log_n - n0), 1);
      chk(diag_addr == 32'h4010 && diag_data == 32'hE1, "R7 failed entry visible",
          diag_addr, 32'h4010);
      busy = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (bus_req) busy++; end
      chk(busy == 0, "R6 no bus cycle while flag set", 32'(busy), 0);
      irq_en = 1'b0;
      @(negedge clk);
      chk(!irq, "R5 irq masked", 32'(irq), 0);
      irq_en = 1'b1;
      pulse(0);
      wait_cycles(20);
      chk(!st_berr && !irq, "R10 bus error cleared", 32'(st_berr), 0);
      chk(log_n == n0 + 2 && log_a[n0+1] == 32'h4020, "R6 resumes, failed not reissued",
          log_a[n0+1], 32'h4020);
      err_at = -1;
   endtask

   task automatic t_full_timeout;
      int w; logic ok, er; logic [31:0] rd;
      int n0, acks;
      stall = 1'b1; lat = 0; to_en = 1'b0;
      n0 = log_n;
      acks = 0;
      for (int i = 0; i < 16; i++) begin
         cpu_access(1'b1, 1'b0, 32'h8000 + 32'(i*4), 32'(i), 5, w, ok, er, rd);
         if (ok && w == 0) acks++;
      end
      chk(acks == 16, "R1 fifteen queued plus output stage", 32'(acks), 16);
      cpu_access(1'b1, 1'b0, 32'h9000, 32'h99, 600, w, ok, er, rd);
      chk(!ok && !er, "R8 full queue holds, timeout off", {30'd0, ok, er}, 0);
      chk(!st_lto && !st_lberr, "R8 no flag with timeout off", 32'(st_lto), 0);
      to_en = 1'b1;
      cpu_access(1'b1, 1'b0, 32'h9000, 32'h99, 2000, w, ok, er, rd);
      chk(er && !ok, "R9 local error on timeout", 32'(er), 1);
      chk(w >= LIMIT && w <= LIMIT + 1, "R9 timeout length", 32'(w), 32'(LIMIT));
      @(negedge clk);
      chk(st_lto && st_lberr, "R9 both flags set", {30'd0, st_lto, st_lberr}, 3);
      pulse(2);
      chk(!st_lto && st_lberr, "R10 independent clear", {30'd0, st_lto, st_lberr}, 1);
      pulse(1);
      chk(!st_lberr, "R10 lberr cleared", 32'(st_lberr), 0);
      to_en = 1'b0;
      stall = 1'b0;
      wait_cycles(80);
      chk(log_n == n0 + 16, "R1 full drain count", 32'(log_n - n0), 16);
      for (int i = 0; i < 16; i++)
         chk(log_a[n0+i] == 32'h8000 + 32'(i*4), "R1 drain order", log_a[n0+i],
             32'h8000 + 32'(i*4));
      // R8: a held write completes once the queue frees up
      stall = 1'b1;
      for (int i = 0; i < 16; i++)
         cpu_access(1'b1, 1'b0, 32'hA000 + 32'(i*4), 32'(i), 5, w, ok, er, rd);
      fork
         begin wait_cycles(40); stall = 1'b0; end
      join_none
      cpu_access(1'b1, 1'b0, 32'hB000, 32'hBB, 400, w, ok, er, rd);
      chk(ok && w >= 40, "R8 held write completes after room", 32'(w), 40);
      wait_cycles(80);
   endtask

   initial begin
      #(4 * 190000);
      if (!done_flag) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      wait_cycles(4);
      rst_n = 1'b1;
      t_reset();
      t_posted();
      t_atomic();
      t_buserr();
      t_full_timeout();
      done_flag = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule